// File: doc/BRIEF.md
# Dual-Framebuffer Raster Scanout

This block produces the raster timing for a display that reads its picture from one of two 64 KB linear framebuffers, and it fetches pixels for that picture. A divider makes a dot tick from the master clock. A horizontal counter steps once per dot. A vertical counter steps once per line. From these counters and a 16-bit mode word, the block computes a VRAM byte address for every dot. The byte that returns is turned into a colour-RAM index, using either 8-bit or packed 4-bit pixels.

The mode word carries several controls:
- a display enable;
- the pixel depth;
- a palette group for 4-bit pixels;
- two letterbox counts that blank lines at the top and bottom of the frame;
- the choice of front framebuffer.

Sync, blank and the palette index come out one dot after the address, so the VRAM has one dot to answer. The raw counter values are also given out, so a CPU can read the beam position.

Top module: `vid_scanout`

## Requirements
- R1: `hpos` advances by one each time the dot tick fires, which is once every DOT_DIV clocks (the first tick comes DOT_DIV clocks after reset is released). It runs from 0 to H_TOTAL-1 and then returns to 0. Between ticks it holds its value.
- R2: `vpos` advances by one on the tick where `hpos` wraps. It runs from 0 to V_TOTAL-1 and then returns to 0. It changes at no other time.
- R3: Mode bit 15 is the enable. While it is 0, `blank` is 1 for every dot. Whenever `blank` is 1, `pal_idx` is 0.
- R4: A dot with h >= H_ACTIVE or v >= V_ACTIVE is blanked. The active picture starts at counter position 0,0.
- R5: Letterbox fields blank whole lines.
  - Mode bits [11:7] hold a top count S: lines with v < S are blanked.
  - Mode bits [6:2] hold a bottom count E: lines with v >= V_ACTIVE-E are blanked.
- R6: For the current dot, `vram_addr[16]` equals mode bit 0, the front-buffer select. `vram_addr[15:0]` is (v*bpl + b) mod 65536, where:
  - with mode bit 14 = 1, bpl = H_ACTIVE and b = h;
  - with mode bit 14 = 0, bpl = H_ACTIVE/2 and b = h/2.
- R7: With mode bit 14 = 1 (8 bpp), an unblanked dot gives `pal_idx` equal to the VRAM byte that was fetched for it.
- R8: With mode bit 14 = 0 (4 bpp), an unblanked dot gives `pal_idx` = {2'b00, mode[13:12], nibble}. The nibble is bits [7:4] of the byte for an even h and bits [3:0] for an odd h.
- R9: `hsync` is 1 for HS_START <= h < HS_END, and `vsync` is 1 for VS_START <= v < VS_END. Both are active high. They, `blank` and `pal_idx` all describe dot d during the dot that follows the one in which `vram_addr` showed d. `vram_data` is sampled at the end of the dot in which its address was presented.
- R10: Mode bit 1 has no effect on any output.
- R11: While reset is held, the outputs are:
  - `hpos` and `vpos` at 0;
  - `blank` at 1;
  - `hsync`, `vsync` and `pal_idx` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 16 | Display mode: enable, depth, palette group, letterbox counts, front select |
| vram_data | input | 8 | Byte read from VRAM for the presented address |
| vram_addr | output | 17 | VRAM byte address; bit 16 picks the 64 KB half |
| pal_idx | output | 8 | Colour RAM index for the current pixel |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | 1 while the pixel is not displayed |
| hpos | output | $clog2(H_TOTAL) | Current horizontal count |
| vpos | output | $clog2(V_TOTAL) | Current vertical count |

## Verification
The bench builds a shrunken raster, with these parameter values:
- H_TOTAL 24 and V_TOTAL 14;
- a 16 by 10 active area;
- hsync at counts 18 to 20 and vsync on line 11;
- DOT_DIV 2.

With these values a whole frame takes 672 clocks, so several complete frames and both counter wraps fit in one run, and each frame can carry a different mode word. The active area is only 10 lines tall. Because the 5-bit letterbox counts can exceed that height, a frame blanked entirely by its top count, and one blanked entirely by its bottom count, both become reachable. The 16-bit wrap of the address offset cannot be reached at these sizes.

// File: rtl/vid_pkg.sv
`timescale 1ns/1ps
package vid_pkg;

    // Mode word, most significant field first.
    typedef struct packed {
        logic       en;         // [15] display enable
        logic       deep;       // [14] 1: 8 bpp, 0: 4 bpp
        logic [1:0] pal;        // [13:12] palette group for 4 bpp
        logic [4:0] top_blank;  // [11:7] lines blanked at frame top
        logic [4:0] bot_blank;  // [6:2] lines blanked at frame bottom
        logic       spare;      // [1] no function
        logic       front;      // [0] front framebuffer half
    } mode_t;

    // Per-dot information handed from fetch to the output stage.
    typedef struct packed {
        logic       blank;
        logic       hsync;
        logic       vsync;
        logic       odd;
        logic       deep;
        logic [1:0] pal;
    } dot_info_t;

    function automatic logic [7:0] pick_index(input logic deep, input logic odd,
                                               input logic [1:0] pal, input logic [7:0] b);
        if (deep)
            return b;
        return {2'b00, pal, (odd ? b[3:0] : b[7:4])};
    endfunction

endpackage

// File: rtl/vid_dot_div.sv
`timescale 1ns/1ps
module vid_dot_div #(
    parameter int DOT_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DOT_DIV > 1) ? $clog2(DOT_DIV) : 1;

    generate
        if (DOT_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam logic [DW-1:0] LAST = DW'(DOT_DIV - 1);
            logic [DW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= '0;
                else if (cnt == LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/vid_raster.sv
`timescale 1ns/1ps
module vid_raster #(
    parameter int H_TOTAL = 416,
    parameter int V_TOTAL = 262,
    parameter int HW      = $clog2(H_TOTAL),
    parameter int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [HW-1:0] h,
    output logic [VW-1:0] v
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            h <= '0;
            v <= '0;
        end else if (tick) begin
            if (h == H_LAST) begin
                h <= '0;
                v <= (v == V_LAST) ? '0 : v + 1'b1;
            end else begin
                h <= h + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vid_fetch.sv
`timescale 1ns/1ps
module vid_fetch
    import vid_pkg::*;
#(
    parameter int H_ACTIVE = 320,
    parameter int V_ACTIVE = 240,
    parameter int HS_START = 336,
    parameter int HS_END   = 384,
    parameter int VS_START = 245,
    parameter int VS_END   = 248,
    parameter int HW       = 9,
    parameter int VW       = 9
) (
    input  logic [HW-1:0] h,
    input  logic [VW-1:0] v,
    input  mode_t         mode,
    output logic [16:0]   addr,
    output dot_info_t     info
);
    localparam int BPL_DEEP    = H_ACTIVE;
    localparam int BPL_SHALLOW = H_ACTIVE / 2;

    int hi, vi, bpl, byte_off, offs;

    always_comb begin
        hi       = int'(h);
        vi       = int'(v);
        bpl      = mode.deep ? BPL_DEEP : BPL_SHALLOW;
        byte_off = mode.deep ? hi : (hi >> 1);
        offs     = vi * bpl + byte_off;
        addr     = {mode.front, offs[15:0]};

        info.blank = !mode.en
                   || (hi >= H_ACTIVE)
                   || (vi >= V_ACTIVE)
                   || (vi < int'(mode.top_blank))
                   || (vi + int'(mode.bot_blank) >= V_ACTIVE);
        info.hsync = (hi >= HS_START) && (hi < HS_END);
        info.vsync = (vi >= VS_START) && (vi < VS_END);
        info.odd   = h[0];
        info.deep  = mode.deep;
        info.pal   = mode.pal;
    end

    logic unused_bits;
    assign unused_bits = ^{mode.spare, offs[31:16]};
endmodule

// File: rtl/vid_pixel_out.sv
`timescale 1ns/1ps
module vid_pixel_out
    import vid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  dot_info_t  info,
    input  logic [7:0] vram_data,
    output logic       blank,
    output logic       hsync,
    output logic       vsync,
    output logic [7:0] pal_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            blank   <= 1'b1;
            hsync   <= 1'b0;
            vsync   <= 1'b0;
            pal_idx <= '0;
        end else if (tick) begin
            blank   <= info.blank;
            hsync   <= info.hsync;
            vsync   <= info.vsync;
            pal_idx <= info.blank ? 8'h00
                                  : pick_index(info.deep, info.odd, info.pal, vram_data);
        end
    end
endmodule

// File: rtl/vid_scanout.sv
`timescale 1ns/1ps
module vid_scanout
    import vid_pkg::*;
#(
    parameter int H_TOTAL  = 416,
    parameter int V_TOTAL  = 262,
    parameter int H_ACTIVE = 320,
    parameter int V_ACTIVE = 240,
    parameter int HS_START = 336,
    parameter int HS_END   = 384,
    parameter int VS_START = 245,
    parameter int VS_END   = 248,
    parameter int DOT_DIV  = 4,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [15:0]   mode_word,
    input  logic [7:0]    vram_data,
    output logic [16:0]   vram_addr,
    output logic [7:0]    pal_idx,
    output logic          hsync,
    output logic          vsync,
    output logic          blank,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos
);
    logic      dot_tick;
    mode_t     mode;
    dot_info_t info;

    assign mode = mode_t'(mode_word);

    vid_dot_div #(.DOT_DIV(DOT_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .tick(dot_tick)
    );

    vid_raster #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)) u_raster (
        .clk (clk),
        .rst (rst),
        .tick(dot_tick),
        .h   (hpos),
        .v   (vpos)
    );

    vid_fetch #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
        .HS_START(HS_START), .HS_END(HS_END),
        .VS_START(VS_START), .VS_END(VS_END),
        .HW(HW), .VW(VW)
    ) u_fetch (
        .h   (hpos),
        .v   (vpos),
        .mode(mode),
        .addr(vram_addr),
        .info(info)
    );

    vid_pixel_out u_out (
        .clk      (clk),
        .rst      (rst),
        .tick     (dot_tick),
        .info     (info),
        .vram_data(vram_data),
        .blank    (blank),
        .hsync    (hsync),
        .vsync    (vsync),
        .pal_idx  (pal_idx)
    );
endmodule

// File: rtl/vid_scanout_chk.sv
`timescale 1ns/1ps
module vid_scanout_chk #(
    parameter int H_TOTAL  = 416,
    parameter int V_TOTAL  = 262,
    parameter int H_ACTIVE = 320,
    parameter int HS_START = 336,
    parameter int HS_END   = 384,
    parameter int HW       = 9,
    parameter int VW       = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic [HW-1:0] hpos,
    input logic [VW-1:0] vpos,
    input logic [15:0]   mode_word,
    input logic          blank,
    input logic          hsync,
    input logic [7:0]    pal_idx
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

    p_hwrap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && hpos == H_LAST) |=> (hpos == '0));

    p_hstep_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && hpos != H_LAST) |=> (int'(hpos) == int'($past(hpos)) + 1));

    p_hhold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(hpos));

    p_vstep_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && hpos == H_LAST && vpos != V_LAST) |=> (int'(vpos) == int'($past(vpos)) + 1));

    p_vwrap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && hpos == H_LAST && vpos == V_LAST) |=> (vpos == '0));

    p_vhold_r2: assert property (@(posedge clk) disable iff (rst)
        !(tick && hpos == H_LAST) |=> $stable(vpos));

    p_disable_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !mode_word[15]) |=> blank);

    p_blank_idx_r3: assert property (@(posedge clk) disable iff (rst)
        blank |-> (pal_idx == 8'h00));

    p_hblank_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && int'(hpos) >= H_ACTIVE) |=> blank);

    p_hsync_r9: assert property (@(posedge clk) disable iff (rst)
        tick |=> (hsync == ((int'($past(hpos)) >= HS_START) && (int'($past(hpos)) < HS_END))));
endmodule

bind vid_scanout vid_scanout_chk #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_ACTIVE(H_ACTIVE),
    .HS_START(HS_START), .HS_END(HS_END), .HW(HW), .VW(VW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (dot_tick),
    .hpos     (hpos),
    .vpos     (vpos),
    .mode_word(mode_word),
    .blank    (blank),
    .hsync    (hsync),
    .pal_idx  (pal_idx)
);

// File: tb/tb_vid_scanout.sv
`timescale 1ns/1ps
module tb_vid_scanout;
    localparam int HT = 24, VT = 14, HA = 16, VA = 10;
    localparam int HSS = 18, HSE = 21, VSS = 11, VSE = 12;
    localparam int DIV = 2;
    localparam int HW = $clog2(HT), VW = $clog2(VT);
    localparam int FRAME = HT * VT;
    localparam int NFR = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   mode_word;
    logic [7:0]    vram_data;
    logic [16:0]   vram_addr;
    logic [7:0]    pal_idx;
    logic          hsync, vsync, blank;
    logic [HW-1:0] hpos;
    logic [VW-1:0] vpos;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic       blank;
        logic       hs;
        logic       vs;
        logic [7:0] pal;
        string      blank_req;
        string      pal_req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    // VRAM model: byte depends on every address bit used here
    function automatic logic [7:0] mem_f(input logic [16:0] a);
        return a[7:0] ^ {a[16], a[14:8]};
    endfunction
    assign vram_data = mem_f(vram_addr);

    vid_scanout #(
        .H_TOTAL(HT), .V_TOTAL(VT), .H_ACTIVE(HA), .V_ACTIVE(VA),
        .HS_START(HSS), .HS_END(HSE), .VS_START(VSS), .VS_END(VSE),
        .DOT_DIV(DIV)
    ) dut (
        .clk(clk), .rst(rst), .mode_word(mode_word), .vram_data(vram_data),
        .vram_addr(vram_addr), .pal_idx(pal_idx), .hsync(hsync), .vsync(vsync),
        .blank(blank), .hpos(hpos), .vpos(vpos)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_addr(input int h, input int v, input logic [15:0] m);
        int bpl, b, off;
        bpl = m[14] ? HA : HA / 2;
        b   = m[14] ? h : h / 2;
        off = (v * bpl + b) % 65536;
        return {m[0], off[15:0]};
    endfunction

    // driver: push the expected delayed outputs for one dot
    task automatic push_dot(input int h, input int v, input logic [15:0] m);
        exp_t e;
        logic [7:0] byt;
        logic [3:0] nib;
        byt = mem_f(exp_addr(h, v, m));
        nib = (h % 2 == 1) ? byt[3:0] : byt[7:4];
        e.hs = (h >= HSS && h < HSE);
        e.vs = (v >= VSS && v < VSE);
        if (!m[15]) begin
            e.blank = 1'b1; e.blank_req = "R3";
        end else if (h >= HA || v >= VA) begin
            e.blank = 1'b1; e.blank_req = "R4";
        end else if (v < int'(m[11:7]) || v + int'(m[6:2]) >= VA) begin
            e.blank = 1'b1; e.blank_req = "R5";
        end else begin
            e.blank = 1'b0; e.blank_req = "R4";
        end
        if (e.blank) begin
            e.pal = 8'h00; e.pal_req = "R3";
        end else if (m[14]) begin
            e.pal = byt; e.pal_req = "R7";
        end else begin
            e.pal = {2'b00, m[13:12], nib}; e.pal_req = "R8";
        end
        sb.push_back(e);
    endtask

    // monitor: pop one expected item and compare with the outputs
    task automatic pop_check();
        exp_t e;
        e = sb.pop_front();
        chk(blank === e.blank, e.blank_req, "blank", int'(blank), int'(e.blank));
        chk(pal_idx === e.pal, e.pal_req, "pal_idx", int'(pal_idx), int'(e.pal));
        chk(hsync === e.hs, "R9", "hsync", int'(hsync), int'(e.hs));
        chk(vsync === e.vs, "R9", "vsync", int'(vsync), int'(e.vs));
    endtask

    logic [15:0] modes [NFR];

    initial begin
        modes[0] = 16'hC000; // 8 bpp, no letterbox, lower half
        modes[1] = 16'hA10D; // 4 bpp, group 2, top 2, bottom 3, upper half
        modes[2] = 16'h4001; // disabled
        modes[3] = 16'h9F80; // 4 bpp, top count 31: all lines blanked
        modes[4] = 16'hC087; // 8 bpp, top 1, bottom 1, spare bit set, upper half
        modes[5] = 16'hC028; // 8 bpp, bottom count 10: all lines blanked
        modes[6] = 16'hB000; // 4 bpp, group 3, lower half
        mode_word = modes[0];
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(blank === 1'b1, "R11", "blank in reset", int'(blank), 1);
        chk(pal_idx === 8'h00, "R11", "pal_idx in reset", int'(pal_idx), 0);
        chk(hsync === 1'b0 && vsync === 1'b0, "R11", "syncs in reset", int'({hsync, vsync}), 0);
        chk(hpos === '0 && vpos === '0, "R11", "position in reset", int'({hpos, vpos}), 0);
        rst = 1'b0;
        for (int d = 0; d < NFR * FRAME; d++) begin
            int h, v;
            logic [16:0] ea;
            string areq;
            h = d % HT;
            v = (d / HT) % VT;
            @(negedge clk);
            ea = exp_addr(h, v, mode_word);
            areq = mode_word[1] ? "R10" : "R6";
            chk(int'(hpos) == h, "R1", "hpos", int'(hpos), h);
            chk(int'(vpos) == v, "R2", "vpos", int'(vpos), v);
            chk(vram_addr === ea, areq, "vram_addr", int'(vram_addr), int'(ea));
            push_dot(h, v, mode_word);
            @(negedge clk);
            pop_check();
            // between dot ticks the position holds (R1)
            chk(int'(hpos) == (h + 1) % HT, "R1", "hpos after tick", int'(hpos), (h + 1) % HT);
            if ((d + 1) % FRAME == 0 && (d + 1) / FRAME < NFR)
                mode_word = modes[(d + 1) / FRAME];
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule